// File: doc/BRIEF.md
# Paletted Cell Colour Index Generator

This block turns one fetched cell of a paletted display plane into a stream of 8-bit colour indices, one per pixel clock. A cell is either a character-generator row byte combined with the cell's character code (text), or a 24-bit slice of bitmap data (bitmap). The depth setting picks 1 to 4 colour-code bits per pixel. The low code bits always come from the glyph or bitmap data. In text mode the remaining upper code bits are borrowed from the top of the character code. A deeper setting therefore leaves fewer distinct glyphs, and consecutive blocks of character codes paint with successive palette pairs, or quads in the multicolour variant.

The colour code selects one of eight palette bytes held in the upper half of the plane's sixteen register bytes. At 4 bits per pixel the code's top bit takes no part in that selection. Instead it flips bit 2 of the looked-up index. The index space is 32 hues by 8 brightness steps, so this flip gives the same hue at a different brightness. A double-width option holds every pixel for two clocks.

Top module: `cic_color_index_gen`

## Requirements
- R1: While reset is asserted and whenever no pixel is pending, `pix_valid` is 0 and `pix_index` is 8'h00.
- R2: `bpp_sel` values 0, 1, 2, 3 mean 1, 2, 3, 4 bits per pixel. Palette entry k (k = 0..7) is `plane_regs[8*(8+k) +: 8]`. Register bytes 0..7 never reach the output. The low three bits of the colour code select the entry.
- R3: Text mode (`bitmap_mode`=0) without multicolour gives 8 pixels from `data_in[7:0]`, bit 7 first. The code's bit 0 is the glyph bit. Code bits 1 to bpp-1 are `char_code` bits 7-(bpp-2) up to 7, with `char_code[7]` as the most significant.
- R4: Text multicolour at 2, 3 or 4 bpp gives 4 pixels from `data_in[7:0]`, bits 7:6 first. These two bits form code bits 1:0. The top bpp-2 code bits come from the top of `char_code`, with `char_code[7]` as the most significant.
- R5: `multi_en` has no effect at 1 bpp, where text behaves as in R3. It also has no effect in bitmap mode.
- R6: Bitmap mode gives 24/bpp pixels from `data_in[23:0]`, most significant bits first, bpp bits per pixel. These bits are the colour code directly, and `char_code` is unused.
- R7: At 4 bpp the code's bit 3 does not take part in entry selection. When it is 1, bit 2 of the looked-up entry is inverted. Below 4 bpp no bit is inverted.
- R8: With `double_wide` set, each pixel is presented for two consecutive clocks.
- R9: A `load` sampled at a rising edge makes the cell's first pixel visible right after that edge. Each further edge advances one pixel, or one hold step with R8. `pix_valid` falls after the last pixel.
- R10: A `load` while a cell is still playing drops the rest of that cell and starts the new one at the next edge. A load on the last pixel gives a gapless stream.
- R11: Configuration, `char_code` and `data_in` are captured at the load. Changing them while the cell plays has no effect on its pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Start a new cell with the present inputs |
| bpp_sel | input | 2 | Depth code, 0..3 for 1..4 bits per pixel |
| multi_en | input | 1 | Multicolour text (2-bit glyph pixels) |
| bitmap_mode | input | 1 | 1 = bitmap cell, 0 = text cell |
| double_wide | input | 1 | Hold every pixel two clocks |
| char_code | input | 8 | Character code of the text cell |
| data_in | input | 24 | Glyph byte in [7:0] or bitmap bits [23:0] |
| plane_regs | input | 128 | Sixteen plane register bytes, byte n at [8n+7:8n] |
| pix_valid | output | 1 | A pixel is being presented |
| pix_index | output | 8 | Final colour index of the current pixel |

## Verification
A new load can arrive in the same cycle the sequencer would advance. This happens both mid-cell and on the final pixel. The bench provokes both cases. It judges them by requiring the new cell's first pixel exactly one edge later, with no leftover pixel from the old cell and no idle gap. The half-bright flip also meets a palette selection in every 4 bpp pixel. Cells whose borrowed top bit is set and cells whose borrowed top bit is clear are compared against the same palette entries. This separates a flipped brightness from a wrongly chosen entry.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam int DATA_W    = 24;
    localparam int GLYPH_W   = 8;
    localparam int CC_W      = 8;
    localparam int STOLEN_W  = 4;
    localparam int CODE_W    = 4;
    localparam int COLOR_W   = 8;
    localparam int NREG      = 16;
    localparam int PAL_N     = 8;
    localparam int PAL_BASE  = NREG - PAL_N;
    localparam int SEL_W     = $clog2(PAL_N);
    localparam int HB_BIT    = 2;
    localparam int CNT_W     = $clog2(DATA_W + 1);

    typedef enum logic [1:0] {
        BPP1 = 2'd0,
        BPP2 = 2'd1,
        BPP3 = 2'd2,
        BPP4 = 2'd3
    } bpp_e;

    typedef struct packed {
        bpp_e bpp;
        logic multi;
        logic bitmap;
        logic dbl;
    } cell_cfg_t;

    function automatic logic multi_active(cell_cfg_t c);
        return c.multi && !c.bitmap && (c.bpp != BPP1);
    endfunction

    function automatic int pix_width(cell_cfg_t c);
        if (c.bitmap)
            return int'(c.bpp) + 1;
        else if (multi_active(c))
            return 2;
        else
            return 1;
    endfunction

    function automatic logic [CNT_W-1:0] pix_count(cell_cfg_t c);
        if (c.bitmap)
            return CNT_W'(DATA_W / (int'(c.bpp) + 1));
        else if (multi_active(c))
            return CNT_W'(GLYPH_W / 2);
        else
            return CNT_W'(GLYPH_W);
    endfunction

endpackage

// File: rtl/cic_pixel_seq.sv
module cic_pixel_seq
    import cic_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  cell_cfg_t           cfg_in,
    input  logic [STOLEN_W-1:0] cc_in,
    input  logic [DATA_W-1:0]   data_in,
    output logic                active,
    output logic [CODE_W-1:0]   head,
    output cell_cfg_t           cfg_q,
    output logic [STOLEN_W-1:0] cc_q
);

    typedef struct packed {
        logic [DATA_W-1:0]   shreg;
        logic [CNT_W-1:0]    cnt;
        logic                phase;
        cell_cfg_t           cfg;
        logic [STOLEN_W-1:0] cc;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            if (cfg_in.bitmap)
                st_d.shreg = data_in;
            else
                st_d.shreg = {data_in[GLYPH_W-1:0], {(DATA_W-GLYPH_W){1'b0}}};
            st_d.cnt   = pix_count(cfg_in);
            st_d.phase = 1'b0;
            st_d.cfg   = cfg_in;
            st_d.cc    = cc_in;
        end else if (st_q.cnt != '0) begin
            if (st_q.cfg.dbl && !st_q.phase) begin
                st_d.phase = 1'b1;
            end else begin
                st_d.phase = 1'b0;
                st_d.shreg = st_q.shreg << pix_width(st_q.cfg);
                st_d.cnt   = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign active = (st_q.cnt != '0);
    assign head   = st_q.shreg[DATA_W-1 -: CODE_W];
    assign cfg_q  = st_q.cfg;
    assign cc_q   = st_q.cc;

    a_r8_hold_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (active && st_q.cfg.dbl && !st_q.phase && !load) |=> ($stable(head) && active));

    a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !st_q.cfg.dbl && !load) |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));

endmodule

// File: rtl/cic_code_extract.sv
module cic_code_extract
    import cic_pkg::*;
(
    input  cell_cfg_t           cfg,
    input  logic [STOLEN_W-1:0] cc_hi,
    input  logic [CODE_W-1:0]   head,
    output logic [CODE_W-1:0]   code
);

    int                w;
    int                stolen;
    logic [CODE_W-1:0] pix_bits;
    logic [CODE_W-1:0] hi_bits;

    always_comb begin
        w = pix_width(cfg);
        if (cfg.bitmap)
            stolen = 0;
        else
            stolen = int'(cfg.bpp) + 1 - w;
        pix_bits = head >> (CODE_W - w);
        hi_bits  = cc_hi >> (STOLEN_W - stolen);
        code     = CODE_W'(hi_bits << w) | pix_bits;
    end

endmodule

// File: rtl/cic_palette_lookup.sv
module cic_palette_lookup
    import cic_pkg::*;
(
    input  logic [PAL_N*COLOR_W-1:0] pal_bytes,
    input  logic [CODE_W-1:0]        code,
    input  logic                     deep,
    output logic [COLOR_W-1:0]       index
);

    logic [COLOR_W-1:0] entry [PAL_N];
    logic [SEL_W-1:0]   sel;
    logic               dim_flip;

    for (genvar k = 0; k < PAL_N; k++) begin : g_entry
        assign entry[k] = pal_bytes[k*COLOR_W +: COLOR_W];
    end

    always_comb begin
        sel      = code[SEL_W-1:0];
        dim_flip = deep && code[CODE_W-1];
        index    = entry[sel];
        index[HB_BIT] = entry[sel][HB_BIT] ^ dim_flip;
    end

endmodule

// File: rtl/cic_color_index_gen.sv
module cic_color_index_gen
    import cic_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [1:0]               bpp_sel,
    input  logic                     multi_en,
    input  logic                     bitmap_mode,
    input  logic                     double_wide,
    input  logic [CC_W-1:0]          char_code,
    input  logic [DATA_W-1:0]        data_in,
    input  logic [NREG*COLOR_W-1:0]  plane_regs,
    output logic                     pix_valid,
    output logic [COLOR_W-1:0]       pix_index
);

    cell_cfg_t           cfg_in;
    cell_cfg_t           cfg_q;
    logic                active;
    logic [CODE_W-1:0]   head;
    logic [STOLEN_W-1:0] cc_q;
    logic [CODE_W-1:0]   code;
    logic [COLOR_W-1:0]  looked_up;
    logic                unused_inputs;

    assign unused_inputs = ^{plane_regs[PAL_BASE*COLOR_W-1:0], char_code[CC_W-STOLEN_W-1:0]};

    always_comb begin
        cfg_in.bpp    = bpp_e'(bpp_sel);
        cfg_in.multi  = multi_en;
        cfg_in.bitmap = bitmap_mode;
        cfg_in.dbl    = double_wide;
    end

    cic_pixel_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .cfg_in  (cfg_in),
        .cc_in   (char_code[CC_W-1 -: STOLEN_W]),
        .data_in (data_in),
        .active  (active),
        .head    (head),
        .cfg_q   (cfg_q),
        .cc_q    (cc_q)
    );

    cic_code_extract u_code (
        .cfg   (cfg_q),
        .cc_hi (cc_q),
        .head  (head),
        .code  (code)
    );

    cic_palette_lookup u_pal (
        .pal_bytes (plane_regs[NREG*COLOR_W-1 : PAL_BASE*COLOR_W]),
        .code      (code),
        .deep      (cfg_q.bpp == BPP4),
        .index     (looked_up)
    );

    assign pix_valid = active;
    assign pix_index = active ? looked_up : '0;

    a_r9_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> pix_valid);

    a_r1_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_valid && !load) |=> (!pix_valid && pix_index == '0));

    a_r7_no_flip_shallow: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && cfg_q.bpp != BPP4) |-> !code[CODE_W-1]);

    a_r5_mono_width: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !cfg_q.bitmap && cfg_q.bpp == BPP1) |-> (code[CODE_W-1:1] == '0));

endmodule

// File: tb/cic_color_index_gen_test.sv
module cic_color_index_gen_test;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [1:0]   bpp_sel = 2'd0;
    logic         multi_en = 1'b0;
    logic         bitmap_mode = 1'b0;
    logic         double_wide = 1'b0;
    logic [7:0]   char_code = 8'h00;
    logic [23:0]  data_in = 24'h0;
    logic [127:0] plane_regs;
    logic         pix_valid;
    logic [7:0]   pix_index;

    int checks = 0;
    int errors = 0;
    logic [7:0] pal [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    cic_color_index_gen uut (
        .clk(clk), .rst_n(rst_n), .load(load), .bpp_sel(bpp_sel),
        .multi_en(multi_en), .bitmap_mode(bitmap_mode), .double_wide(double_wide),
        .char_code(char_code), .data_in(data_in), .plane_regs(plane_regs),
        .pix_valid(pix_valid), .pix_index(pix_index)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model(int i, logic [1:0] bs, logic m, logic bm,
                                         logic [7:0] cc, logic [23:0] d);
        int b = int'(bs) + 1;
        logic [3:0] c = 4'h0;
        logic hb;
        if (bm) begin
            for (int k = 0; k < b; k++) c[b-1-k] = d[23 - i*b - k];
        end else if (m && b >= 2) begin
            c[1] = d[7 - 2*i];
            c[0] = d[6 - 2*i];
            for (int k = 0; k < b-2; k++) c[b-1-k] = cc[7-k];
        end else begin
            c[0] = d[7 - i];
            for (int k = 0; k < b-1; k++) c[b-1-k] = cc[7-k];
        end
        hb = (b == 4) && c[3];
        return pal[c[2:0]] ^ (hb ? 8'h04 : 8'h00);
    endfunction

    function automatic int npix(logic [1:0] bs, logic m, logic bm);
        if (bm) return 24 / (int'(bs) + 1);
        if (m && bs != 2'd0) return 4;
        return 8;
    endfunction

    task automatic drive(input logic [1:0] bs, input logic m, input logic bm, input logic dw,
                         input logic [7:0] cc, input logic [23:0] d);
        bpp_sel = bs; multi_en = m; bitmap_mode = bm; double_wide = dw;
        char_code = cc; data_in = d; load = 1'b1;
    endtask

    task automatic scramble();
        load = 1'b0;
        bpp_sel = ~bpp_sel; multi_en = ~multi_en; bitmap_mode = ~bitmap_mode;
        double_wide = ~double_wide; char_code = ~char_code; data_in = ~data_in;
    endtask

    // Plays pixels of an already loaded cell; first pixel is visible now.
    task automatic play(input string req, input logic [1:0] bs, input logic m, input logic bm,
                        input logic dw, input logic [7:0] cc, input logic [23:0] d, input int upto);
        for (int i = 0; i < upto; i++) begin
            for (int h = 0; h < (dw ? 2 : 1); h++) begin
                check(pix_valid === 1'b1, req, 16'(pix_valid), 16'h1);
                check(pix_index === model(i, bs, m, bm, cc, d), req,
                      16'(pix_index), 16'(model(i, bs, m, bm, cc, d)));
                if (!(i == upto-1 && h == (dw ? 1 : 0))) @(negedge clk);
            end
        end
    endtask

    task automatic run_cell(input string req, input logic [1:0] bs, input logic m, input logic bm,
                            input logic dw, input logic [7:0] cc, input logic [23:0] d);
        drive(bs, m, bm, dw, cc, d);
        @(negedge clk);
        scramble();   // R11: inputs changed after capture
        play(req, bs, m, bm, dw, cc, d, npix(bs, m, bm));
        @(negedge clk);
        check(pix_valid === 1'b0, {req, " end R9"}, 16'(pix_valid), 16'h0);
        check(pix_index === 8'h00, {req, " idle R1"}, 16'(pix_index), 16'h0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(pix_valid === 1'b0 && pix_index === 8'h00, "R1 reset",
              {8'(pix_valid), pix_index}, 16'h0);
        drive(2'd3, 1'b0, 1'b1, 1'b0, 8'hFF, 24'hFFFFFF);
        @(negedge clk);
        load = 1'b0;
        check(pix_valid === 1'b0, "R1 load under reset", 16'(pix_valid), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pix_valid === 1'b0 && pix_index === 8'h00, "R1 after reset",
              {8'(pix_valid), pix_index}, 16'h0);
    endtask

    task automatic t_text_plain();
        run_cell("R3 R2 text 1bpp", 2'd0, 1'b0, 1'b0, 1'b0, 8'hFF, 24'h0000A5);
        run_cell("R3 text 2bpp pair1", 2'd1, 1'b0, 1'b0, 1'b0, 8'h80, 24'h00003C);
        run_cell("R3 text 2bpp pair0", 2'd1, 1'b0, 1'b0, 1'b0, 8'h7F, 24'h0000C3);
        run_cell("R3 text 3bpp", 2'd2, 1'b0, 1'b0, 1'b0, 8'h40, 24'h00009B);
        run_cell("R3 text 3bpp hi", 2'd2, 1'b0, 1'b0, 1'b0, 8'hC0, 24'h000064);
    endtask

    task automatic t_text_multi();
        run_cell("R4 multi 2bpp", 2'd1, 1'b1, 1'b0, 1'b0, 8'hFF, 24'h00001B);
        run_cell("R4 multi 3bpp", 2'd2, 1'b1, 1'b0, 1'b0, 8'h80, 24'h0000E4);
        run_cell("R4 multi 4bpp", 2'd3, 1'b1, 1'b0, 1'b0, 8'h40, 24'h00006C);
        run_cell("R5 multi at 1bpp", 2'd0, 1'b1, 1'b0, 1'b0, 8'hFF, 24'h000059);
    endtask

    task automatic t_half_bright();
        run_cell("R7 text 4bpp dark", 2'd3, 1'b0, 1'b0, 1'b0, 8'h20, 24'h0000AA);
        run_cell("R7 text 4bpp flip", 2'd3, 1'b0, 1'b0, 1'b0, 8'hA0, 24'h0000AA);
        run_cell("R7 multi 4bpp flip", 2'd3, 1'b1, 1'b0, 1'b0, 8'hC0, 24'h00001B);
    endtask

    task automatic t_bitmap();
        run_cell("R6 bitmap 1bpp", 2'd0, 1'b0, 1'b1, 1'b0, 8'hFF, 24'hA5C3F0);
        run_cell("R6 bitmap 2bpp", 2'd1, 1'b0, 1'b1, 1'b0, 8'h00, 24'h1B6CE4);
        run_cell("R6 bitmap 3bpp", 2'd2, 1'b0, 1'b1, 1'b0, 8'hFF, 24'h053977);
        run_cell("R7 R6 bitmap 4bpp", 2'd3, 1'b0, 1'b1, 1'b0, 8'h00, 24'h89ABF1);
        run_cell("R5 bitmap multi", 2'd1, 1'b1, 1'b1, 1'b0, 8'hFF, 24'hE41B93);
    endtask

    task automatic t_double();
        run_cell("R8 double text", 2'd1, 1'b0, 1'b0, 1'b1, 8'h80, 24'h000096);
        run_cell("R8 double bitmap", 2'd2, 1'b0, 1'b1, 1'b1, 8'h00, 24'hFAC688);
    endtask

    task automatic t_restart();
        drive(2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 24'h0000F0);
        @(negedge clk);
        scramble();
        play("R10 first cell", 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 24'h0000F0, 3);
        drive(2'd3, 1'b0, 1'b1, 1'b0, 8'h00, 24'h7F1E2D);   // lands mid-cell
        @(negedge clk);
        scramble();
        play("R10 restart mid", 2'd3, 1'b0, 1'b1, 1'b0, 8'h00, 24'h7F1E2D, 6);
        @(negedge clk);
        check(pix_valid === 1'b0, "R10 no leftover", 16'(pix_valid), 16'h0);
        // chained: load on the last pixel of a double-wide cell
        drive(2'd1, 1'b1, 1'b0, 1'b1, 8'h00, 24'h0000D8);
        @(negedge clk);
        scramble();
        play("R10 chain A", 2'd1, 1'b1, 1'b0, 1'b1, 8'h00, 24'h0000D8, 4);
        drive(2'd2, 1'b0, 1'b0, 1'b0, 8'hC0, 24'h000033);
        @(negedge clk);
        scramble();
        play("R10 chain B", 2'd2, 1'b0, 1'b0, 1'b0, 8'hC0, 24'h000033, 8);
        @(negedge clk);
        check(pix_valid === 1'b0, "R10 chain end", 16'(pix_valid), 16'h0);
        @(negedge clk);
    endtask

    task automatic t_low_regs();
        // R2: lower register bytes are ignored
        plane_regs[63:0] = 64'h0;
        run_cell("R2 low regs cleared", 2'd3, 1'b0, 1'b1, 1'b0, 8'h00, 24'h0123CD);
        plane_regs[63:0] = {8{8'hEE}};
    endtask

    initial begin
        for (int k = 0; k < 8; k++) pal[k] = 8'(8'h10 + k * 8'h21);
        plane_regs[63:0] = {8{8'hEE}};
        for (int k = 0; k < 8; k++) plane_regs[(8+k)*8 +: 8] = pal[k];
        @(negedge clk);
        t_reset();
        t_text_plain();
        t_text_multi();
        t_half_bright();
        t_bitmap();
        t_double();
        t_restart();
        t_low_regs();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule